// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a 32-bit processor core that fetches, decodes and completes one instruction in each clock cycle. It holds the program counter, a 32-entry by 32-bit register file, the arithmetic unit with its operation decoder, the main decoder and the next-address selection. It reads instructions from a combinational program memory port. It reaches data memory through a port that carries an address, write data, read data, a read strobe and a write strobe. The data read comes back in the same cycle.

The instruction set covers register-to-register arithmetic and logic, word load and store, add-immediate and branch-if-equal. It also has a wider set of control transfers than the usual teaching subset. These are an absolute jump, a jump that saves the return address, a jump to a register, and a jump to the return address plus a register value. Encodings that are not recognised do nothing and fall through to the next word.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter, shown on `imem_addr`, to 0. After reset, each non-transfer instruction (add-immediate, load, store, arithmetic, or an unrecognised encoding) moves the counter on by 4.
- R2: Register-format words (opcode 000000, bits 10..6 zero) write the result to rd. The function field in bits 5..0 selects the operation: 100000 add, 100010 subtract, 100100 and, 100101 or, 100111 nor, 101010 signed set-less-than (result 1 or 0).
- R3: Register 0 always reads as zero. Writes aimed at it are discarded.
- R4: Load (opcode 100011) raises `dmem_re`, keeps `dmem_we` low, drives rs plus the sign-extended 16-bit offset on `dmem_addr`, and writes `dmem_rdata` into rt.
- R5: Store (opcode 101011) raises `dmem_we`, keeps `dmem_re` low, puts rs plus the sign-extended offset on `dmem_addr` and rt on `dmem_wdata`, and writes no register. `dmem_we` is high for no other instruction.
- R6: Add-immediate (opcode 001000) writes rs plus the sign-extended immediate into rt.
- R7: Branch-if-equal (opcode 000100) jumps to PC+4 plus the sign-extended offset times 4 when rs equals rt. Otherwise it goes to PC+4.
- R8: Jump (opcode 000010) sets the counter to the top 4 bits of PC+4, then bits 25..0 of the word, then two zeros. It writes nothing.
- R9: Jump-and-save (opcode 000011) uses the same target as R8 and writes PC+4 into register 31.
- R10: Register jump (opcode 000000, function 001000) loads the counter with rs and writes no register, whatever its rd field holds.
- R11: Relative register jump (opcode 000000, function 001001) loads the counter with PC+4 plus rs. It writes no register and no memory.
- R12: Unrecognised opcodes, unrecognised function codes and register-format words with nonzero bits 10..6 write no register and no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Program counter, used as the fetch address |
| imem_data | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, combinational |
| dmem_re | output | 1 | Load strobe |
| dmem_we | output | 1 | Store strobe, memory writes on the next rising edge |

## Verification
The hardest case to reach is the jump that keeps the top four counter bits. A small program memory only ever runs code near address zero, where those bits are zero and a broken splice would go unseen. The bench therefore loads 0xF0000020 from data memory and register-jumps there. Program memory decodes only the low address bits, so the code continues from a low word. The absolute jump and the jump-and-save that follow must then keep 0xF in the upper nibble of the counter and of the saved return address. Register contents cannot be observed directly, so every register effect is checked by a later store.

// File: rtl/sc_core.sv
module sc_core (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  input  logic [31:0] dmem_rdata,
  output logic        dmem_re,
  output logic        dmem_we
);
  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_ADDI  = 6'b001000;
  localparam logic [5:0] OP_J     = 6'b000010;
  localparam logic [5:0] OP_JAL   = 6'b000011;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_NOR = 6'b100111;
  localparam logic [5:0] FN_SLT = 6'b101010;
  localparam logic [5:0] FN_JR  = 6'b001000;
  localparam logic [5:0] FN_JRR = 6'b001001;

  localparam logic [3:0] AC_AND = 4'b0000;
  localparam logic [3:0] AC_OR  = 4'b0001;
  localparam logic [3:0] AC_ADD = 4'b0010;
  localparam logic [3:0] AC_SUB = 4'b0110;
  localparam logic [3:0] AC_SLT = 4'b0111;
  localparam logic [3:0] AC_NOR = 4'b1100;

  logic [31:0] pc, pc4, rs_val, rt_val, imm_ext, alu_b, alu_y, wb_data, nxt_pc;
  logic [5:0]  opcode, funct;
  logic [4:0]  rs, rt, rd, wr_reg;
  logic        shamt_zero;
  logic        reg_dst, alu_src, mem_to_reg, reg_write, mem_read, mem_write;
  logic        branch, jump, link, jr_sel, jrr_sel;
  logic [1:0]  alu_op;
  logic [3:0]  alu_ctl;
  logic [31:0] regs [32];

  assign opcode     = imem_data[31:26];
  assign rs         = imem_data[25:21];
  assign rt         = imem_data[20:16];
  assign rd         = imem_data[15:11];
  assign funct      = imem_data[5:0];
  assign shamt_zero = (imem_data[10:6] == 5'd0);
  assign imm_ext    = {{16{imem_data[15]}}, imem_data[15:0]};
  assign pc4        = pc + 32'd4;

  always_comb begin
    reg_dst    = 1'b0;
    alu_src    = 1'b0;
    mem_to_reg = 1'b0;
    reg_write  = 1'b0;
    mem_read   = 1'b0;
    mem_write  = 1'b0;
    branch     = 1'b0;
    jump       = 1'b0;
    link       = 1'b0;
    jr_sel     = 1'b0;
    jrr_sel    = 1'b0;
    alu_op     = 2'b00;
    case (opcode)
      OP_RTYPE: begin
        reg_dst = 1'b1;
        alu_op  = 2'b10;
        if (shamt_zero) begin
          case (funct)
            FN_ADD, FN_SUB, FN_AND, FN_OR, FN_NOR, FN_SLT: reg_write = 1'b1;
            FN_JR:  jr_sel  = 1'b1;
            FN_JRR: jrr_sel = 1'b1;
            default: ;
          endcase
        end
      end
      OP_LW: begin
        alu_src    = 1'b1;
        mem_to_reg = 1'b1;
        reg_write  = 1'b1;
        mem_read   = 1'b1;
      end
      OP_SW: begin
        alu_src   = 1'b1;
        mem_write = 1'b1;
      end
      OP_BEQ: begin
        branch = 1'b1;
        alu_op = 2'b01;
      end
      OP_ADDI: begin
        alu_src   = 1'b1;
        reg_write = 1'b1;
      end
      OP_J: jump = 1'b1;
      OP_JAL: begin
        jump      = 1'b1;
        link      = 1'b1;
        reg_write = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (alu_op)
      2'b00:   alu_ctl = AC_ADD;
      2'b01:   alu_ctl = AC_SUB;
      default: begin
        case (funct)
          FN_SUB:  alu_ctl = AC_SUB;
          FN_AND:  alu_ctl = AC_AND;
          FN_OR:   alu_ctl = AC_OR;
          FN_NOR:  alu_ctl = AC_NOR;
          FN_SLT:  alu_ctl = AC_SLT;
          default: alu_ctl = AC_ADD;
        endcase
      end
    endcase
  end

  assign alu_b = alu_src ? imm_ext : rt_val;

  always_comb begin
    case (alu_ctl)
      AC_AND:  alu_y = rs_val & alu_b;
      AC_OR:   alu_y = rs_val | alu_b;
      AC_ADD:  alu_y = rs_val + alu_b;
      AC_SUB:  alu_y = rs_val - alu_b;
      AC_SLT:  alu_y = {31'd0, $signed(rs_val) < $signed(alu_b)};
      AC_NOR:  alu_y = ~(rs_val | alu_b);
      default: alu_y = 32'd0;
    endcase
  end

  always_comb begin
    if (jr_sel)
      nxt_pc = rs_val;
    else if (jrr_sel)
      nxt_pc = pc4 + rs_val;
    else if (jump)
      nxt_pc = {pc4[31:28], imem_data[25:0], 2'b00};
    else if (branch && (alu_y == 32'd0))
      nxt_pc = pc4 + {imm_ext[29:0], 2'b00};
    else
      nxt_pc = pc4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= 32'd0;
    else     pc <= nxt_pc;
  end

  assign wr_reg  = link ? 5'd31 : (reg_dst ? rd : rt);
  assign wb_data = link ? pc4 : (mem_to_reg ? dmem_rdata : alu_y);

  always_ff @(posedge clk) begin
    if (!rst && reg_write && wr_reg != 5'd0)
      regs[wr_reg] <= wb_data;
  end

  assign rs_val = (rs == 5'd0) ? 32'd0 : regs[rs];
  assign rt_val = (rt == 5'd0) ? 32'd0 : regs[rt];

  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_re    = mem_read;
  assign dmem_we    = mem_write;
endmodule

// File: rtl/sc_core_props.sv
module sc_core_props (
  input logic        clk,
  input logic        rst,
  input logic [31:0] imem_addr,
  input logic [31:0] imem_data,
  input logic        dmem_we,
  input logic        dmem_re
);
  logic [5:0]  op;
  logic [31:0] seq_addr;
  assign op       = imem_data[31:26];
  assign seq_addr = imem_addr + 32'd4;

  AST_RESET_PC: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> imem_addr == 32'd0); // R1

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (op == 6'b100011 || op == 6'b101011 || op == 6'b001000) |=> imem_addr == $past(seq_addr)); // R1

  AST_LOAD_STROBE: assert property (@(posedge clk) disable iff (rst)
    op == 6'b100011 |-> dmem_re && !dmem_we); // R4

  AST_STORE_ONLY: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> op == 6'b101011); // R5

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(dmem_we && dmem_re)); // R5

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    op[5:1] == 5'b00001 |=> imem_addr == {$past(seq_addr[31:28]), $past(imem_data[25:0]), 2'b00}); // R8
endmodule

bind sc_core sc_core_props u_props (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
  .dmem_we(dmem_we), .dmem_re(dmem_re)
);

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;
  localparam logic [5:0] OP_LW = 6'b100011, OP_SW = 6'b101011, OP_BEQ = 6'b000100;
  localparam logic [5:0] OP_ADDI = 6'b001000, OP_J = 6'b000010, OP_JAL = 6'b000011;
  localparam logic [5:0] FN_ADD = 6'b100000, FN_SUB = 6'b100010, FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR = 6'b100101, FN_NOR = 6'b100111, FN_SLT = 6'b101010;
  localparam logic [5:0] FN_JR = 6'b001000, FN_JRR = 6'b001001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_re, dmem_we;
  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  logic        pre_en = 1'b0;
  logic [5:0]  pre_idx = 6'd0;
  logic [31:0] pre_val = 32'd0;

  sc_core uut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .dmem_re(dmem_re), .dmem_we(dmem_we)
  );

  assign imem_data  = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (pre_en) dmem[pre_idx] <= pre_val;
    else if (!rst && dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
  end

  int vectors = 0;
  int fails = 0;
  logic [31:0] pcs [64];
  logic [31:0] st_addr [16];
  logic [31:0] st_data [16];
  int nst, nld;
  logic [31:0] ld_addr;
  logic st_re;

  function automatic logic [31:0] enc_r(int s, int t, int d, logic [5:0] f);
    return {6'b000000, s[4:0], t[4:0], d[4:0], 5'b00000, f};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int s, int t, int imm);
    return {op, s[4:0], t[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] enc_j(logic [5:0] op, int w);
    return {op, w[25:0]};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic begin_test();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < 64; i++) imem[i] = 32'd0;
    check("R1", "counter held at zero in reset", imem_addr, 32'd0);
  endtask

  task automatic preload(int idx, logic [31:0] val);
    pre_idx = idx[5:0];
    pre_val = val;
    pre_en  = 1'b1;
    @(negedge clk);
    pre_en  = 1'b0;
  endtask

  task automatic go(int n);
    for (int i = 0; i < 16; i++) begin
      st_addr[i] = 32'hBAD0BAD0;
      st_data[i] = 32'hBAD0BAD0;
    end
    nst = 0; nld = 0; st_re = 1'b0; ld_addr = 32'hBAD0BAD0;
    rst = 1'b0;
    for (int k = 0; k < n; k++) begin
      pcs[k] = imem_addr;
      if (dmem_we) begin
        if (nst < 16) begin
          st_addr[nst] = dmem_addr;
          st_data[nst] = dmem_wdata;
        end
        nst++;
        if (dmem_re) st_re = 1'b1;
      end
      if (dmem_re) begin
        ld_addr = dmem_addr;
        nld++;
        if (dmem_we) st_re = 1'b1;
      end
      @(negedge clk);
    end
  endtask

  task automatic test_sequence();
    begin_test();
    imem[0] = enc_i(OP_ADDI, 0, 1, 5);
    imem[1] = enc_i(OP_ADDI, 0, 2, -3);
    imem[2] = enc_i(OP_SW, 0, 1, 0);
    imem[3] = enc_i(OP_SW, 0, 2, 4);
    go(5);
    for (int k = 0; k < 5; k++) check("R1", "sequential counter", pcs[k], 32'(k * 4));
    check("R6", "addi positive", st_data[0], 32'd5);
    check("R6", "addi negative", st_data[1], 32'hFFFFFFFD);
    check("R5", "store address", st_addr[1], 32'd4);
    check("R5", "store count", 32'(nst), 32'd2);
  endtask

  task automatic test_alu();
    begin_test();
    imem[0]  = enc_i(OP_ADDI, 0, 1, 12);
    imem[1]  = enc_i(OP_ADDI, 0, 2, 10);
    imem[2]  = enc_i(OP_ADDI, 0, 9, -1);
    imem[3]  = enc_r(1, 2, 3, FN_ADD);
    imem[4]  = enc_r(1, 2, 4, FN_SUB);
    imem[5]  = enc_r(1, 2, 5, FN_AND);
    imem[6]  = enc_r(1, 2, 6, FN_OR);
    imem[7]  = enc_r(1, 2, 7, FN_NOR);
    imem[8]  = enc_r(9, 1, 8, FN_SLT);
    imem[9]  = enc_r(1, 9, 10, FN_SLT);
    imem[10] = enc_i(OP_SW, 0, 3, 0);
    imem[11] = enc_i(OP_SW, 0, 4, 4);
    imem[12] = enc_i(OP_SW, 0, 5, 8);
    imem[13] = enc_i(OP_SW, 0, 6, 12);
    imem[14] = enc_i(OP_SW, 0, 7, 16);
    imem[15] = enc_i(OP_SW, 0, 8, 20);
    imem[16] = enc_i(OP_SW, 0, 10, 24);
    go(17);
    check("R2", "add", st_data[0], 32'd22);
    check("R2", "sub", st_data[1], 32'd2);
    check("R2", "and", st_data[2], 32'd8);
    check("R2", "or", st_data[3], 32'd14);
    check("R2", "nor", st_data[4], 32'hFFFFFFF1);
    check("R2", "slt signed true", st_data[5], 32'd1);
    check("R2", "slt signed false", st_data[6], 32'd0);
  endtask

  task automatic test_load();
    begin_test();
    preload(5, 32'hDEADBEEF);
    imem[0] = enc_i(OP_ADDI, 0, 1, 16);
    imem[1] = enc_i(OP_LW, 1, 2, 4);
    imem[2] = enc_i(OP_SW, 1, 2, -4);
    go(3);
    check("R4", "load address", ld_addr, 32'd20);
    check("R4", "load strobes", 32'(nld), 32'd1);
    check("R4", "loaded value stored", st_data[0], 32'hDEADBEEF);
    check("R5", "store negative offset", st_addr[0], 32'd12);
    check("R5", "strobes never together", {31'd0, st_re}, 32'd0);
  endtask

  task automatic test_branch();
    begin_test();
    imem[0] = enc_i(OP_ADDI, 0, 1, 3);
    imem[1] = enc_i(OP_ADDI, 0, 2, 3);
    imem[2] = enc_i(OP_BEQ, 1, 2, 2);
    imem[3] = enc_i(OP_SW, 0, 1, 0);
    imem[4] = enc_i(OP_SW, 0, 1, 4);
    imem[5] = enc_i(OP_BEQ, 1, 0, 7);
    imem[6] = enc_i(OP_SW, 0, 2, 8);
    imem[7] = enc_i(OP_BEQ, 0, 0, -8);
    go(7);
    check("R7", "taken forward", pcs[3], 32'd20);
    check("R7", "not taken", pcs[4], 32'd24);
    check("R7", "taken backward", pcs[6], 32'd0);
    check("R7", "skipped stores", 32'(nst), 32'd1);
    check("R7", "surviving store", st_addr[0], 32'd8);
  endtask

  task automatic test_far_jumps();
    begin_test();
    preload(0, 32'hF0000020);
    imem[0] = enc_i(OP_LW, 0, 1, 0);
    imem[1] = enc_r(1, 0, 0, FN_JR);
    imem[8] = enc_j(OP_J, 3);
    imem[3] = enc_j(OP_JAL, 6);
    imem[6] = enc_i(OP_SW, 0, 31, 4);
    go(5);
    check("R10", "register jump", pcs[2], 32'hF0000020);
    check("R8", "jump keeps upper bits", pcs[3], 32'hF000000C);
    check("R9", "jump-and-save target", pcs[4], 32'hF0000018);
    check("R9", "saved return address", st_data[0], 32'hF0000010);
    check("R8", "no store during jumps", 32'(nst), 32'd1);
  endtask

  task automatic test_reg_jumps();
    begin_test();
    imem[0]  = enc_i(OP_ADDI, 0, 5, 77);
    imem[1]  = enc_i(OP_ADDI, 0, 1, 16);
    imem[2]  = enc_r(1, 0, 5, FN_JRR);
    imem[7]  = enc_i(OP_SW, 0, 5, 0);
    imem[8]  = enc_i(OP_ADDI, 0, 6, 48);
    imem[9]  = enc_r(6, 0, 5, FN_JR);
    imem[12] = enc_i(OP_SW, 0, 5, 4);
    go(7);
    check("R11", "relative jump target", pcs[3], 32'd28);
    check("R11", "rd untouched by relative jump", st_data[0], 32'd77);
    check("R10", "register jump target", pcs[6], 32'd48);
    check("R10", "rd untouched by register jump", st_data[1], 32'd77);
    check("R11", "stores only from sw", 32'(nst), 32'd2);
  endtask

  task automatic test_zero_and_undef();
    begin_test();
    imem[0] = enc_i(OP_ADDI, 0, 2, 5);
    imem[1] = enc_i(OP_ADDI, 0, 0, 7);
    imem[2] = enc_i(6'b111111, 0, 2, 1234);
    imem[3] = enc_r(0, 0, 2, 6'b000001);
    imem[4] = enc_r(0, 0, 2, FN_ADD) | 32'h00000040;
    imem[5] = enc_r(2, 2, 0, FN_ADD);
    imem[6] = enc_i(OP_SW, 0, 0, 0);
    imem[7] = enc_i(OP_SW, 0, 2, 4);
    go(8);
    for (int k = 0; k < 8; k++) check("R12", "fall through", pcs[k], 32'(k * 4));
    check("R3", "register 0 reads zero", st_data[0], 32'd0);
    check("R12", "undefined words leave rt/rd", st_data[1], 32'd5);
    check("R12", "no stray stores", 32'(nst), 32'd2);
  endtask

  initial begin
    test_sequence();
    test_alu();
    test_load();
    test_branch();
    test_far_jumps();
    test_reg_jumps();
    test_zero_and_undef();
    begin_test();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule